// File: doc/BRIEF.md
# Four-Mode Timer/Counter Channel

A single timer/counter channel built from two 8-bit count bytes (low and high), a control register and a pair of sticky overflow flags. It advances once per machine cycle from an externally supplied one-cycle `tick` enable, or, in counter mode, once per falling edge seen on an external count pin. Four count shapes are selectable: a 13-bit count, a full 16-bit count, an 8-bit count with automatic reload from the high byte, and a split arrangement in which the two bytes act as two separate 8-bit timers with a flag each.

Software reaches all state through a four-entry byte-wide register port. Offset 0 is the low count byte, offset 1 the high count byte, offset 2 the control byte and offset 3 the flag byte. Counting can be qualified by an external gate pin, so that the channel measures how long that pin stays high.

Top module: `tmr_channel`

## Requirements
- R1: After reset, all four registers read 0 and both flag outputs are 0.
- R2: With mode field 00, each increment advances a 13-bit value whose upper 8 bits are the high byte and lower 5 bits are low-byte bits [4:0]; low-byte bits [7:5] are left unchanged; when the 13-bit value wraps from all ones to zero, flag bit 0 is set (8192 increments from zero give one overflow).
- R3: With mode field 01, each increment advances the 16-bit value {high, low}; the wrap from FFFFh to 0000h sets flag bit 0.
- R4: With mode field 10, the low byte counts alone; an increment at FFh loads the low byte from the high byte and sets flag bit 0; the high byte is not changed by counting.
- R5: With mode field 11, the low byte counts as an 8-bit counter under the channel controls and sets flag bit 0 on FFh to 00h; the high byte increments on every tick while control bit 5 is set, independent of control bits 4..2 and the gate pin, and sets flag bit 1 on FFh to 00h.
- R6: Control bit 3 (gate enable): when 0, control bit 4 (run) alone enables counting; when 1, counting also requires `gate_pin` high.
- R7: Control bit 2 (source select): when 0, every enabled cycle with `tick` high is one increment; when 1, `tick` alone does not count and an increment occurs on a `tick` cycle at which the two-flop synchronized `cnt_pin` is 0 and was 1 at the previous `tick` cycle.
- R8: With run (control bit 4) at 0, the low and high bytes hold their values whatever `tick`, `cnt_pin` and `gate_pin` do (in mode 11 the high byte instead follows bit 5).
- R9: A set flag stays set until a write to offset 3 loads flag bits [1:0] from write data bits [1:0].
- R10: Any register write suppresses all counting in the same cycle, so the written value is what the register holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle machine-cycle enable |
| cnt_pin | input | 1 | External event input, counted on falling edges |
| gate_pin | input | 1 | External gate qualifying the run bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 low, 1 high, 2 control, 3 flags |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| ovf | output | 1 | Main overflow flag (flag bit 0) |
| ovf_hi | output | 1 | Split-mode high-byte overflow flag (flag bit 1) |

## Verification
A wrong count step or a mis-wired mode shows up on the read port in the very next cycle, since the reference model compares the selected register after every clock edge. A flag set early, late or not at all appears on `ovf` or `ovf_hi` in the cycle of the wrap, and a lost synchronizer stage shifts the counter-mode increment by one cycle, which the per-clock comparison catches while the count pin toggles. Long-range faults such as a wrong 13-bit boundary surface only after the full 8192-step run, where the explicit boundary checks land.

// File: rtl/tmr_channel.sv
module tmr_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cnt_pin,
  input  logic       gate_pin,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       ovf,
  output logic       ovf_hi
);

  localparam logic [1:0] M13 = 2'b00, M16 = 2'b01, MRLD = 2'b10, MSPL = 2'b11;

  logic [7:0] lo_q, hi_q, lo_d, hi_d;
  logic [1:0] mode;
  logic       src_ext, gate_en, run, run_hi;
  logic       ovf_q, ovfh_q, ov_set, ovh_set;
  logic       cs1, cs2, cprev;
  logic [13:0] sum13;
  logic [16:0] sum16;
  logic       unused_bits;

  wire enable = run & (~gate_en | gate_pin);
  wire fall   = tick & cprev & ~cs2;
  wire inc    = enable & (src_ext ? fall : tick) & ~reg_wr;
  wire inc_hi = run_hi & tick & ~reg_wr & (mode == MSPL);

  assign sum13 = {1'b0, hi_q, lo_q[4:0]} + 14'd1;
  assign sum16 = {1'b0, hi_q, lo_q} + 17'd1;
  assign unused_bits = ^reg_wdata[7:6];

  always_comb begin
    lo_d = lo_q;
    hi_d = hi_q;
    ov_set = 1'b0;
    ovh_set = 1'b0;
    if (inc) begin
      case (mode)
        M13: begin
          hi_d = sum13[12:5];
          lo_d = {lo_q[7:5], sum13[4:0]};
          ov_set = sum13[13];
        end
        M16: begin
          {hi_d, lo_d} = sum16[15:0];
          ov_set = sum16[16];
        end
        MRLD: begin
          lo_d = (lo_q == 8'hFF) ? hi_q : lo_q + 8'd1;
          ov_set = (lo_q == 8'hFF);
        end
        default: begin
          lo_d = lo_q + 8'd1;
          ov_set = (lo_q == 8'hFF);
        end
      endcase
    end
    if (inc_hi) begin
      hi_d = hi_q + 8'd1;
      ovh_set = (hi_q == 8'hFF);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0; hi_q <= '0; mode <= M13;
      src_ext <= 1'b0; gate_en <= 1'b0; run <= 1'b0; run_hi <= 1'b0;
      ovf_q <= 1'b0; ovfh_q <= 1'b0;
      cs1 <= 1'b0; cs2 <= 1'b0; cprev <= 1'b0;
    end else begin
      cs1 <= cnt_pin;
      cs2 <= cs1;
      if (tick) cprev <= cs2;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: lo_q <= reg_wdata;
          2'd1: hi_q <= reg_wdata;
          2'd2: {run_hi, run, gate_en, src_ext, mode} <= reg_wdata[5:0];
          default: {ovfh_q, ovf_q} <= reg_wdata[1:0];
        endcase
      end else begin
        lo_q <= lo_d;
        hi_q <= hi_d;
        ovf_q <= ovf_q | ov_set;
        ovfh_q <= ovfh_q | ovh_set;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0: reg_rdata = lo_q;
      2'd1: reg_rdata = hi_q;
      2'd2: reg_rdata = {2'b00, run_hi, run, gate_en, src_ext, mode};
      default: reg_rdata = {6'd0, ovfh_q, ovf_q};
    endcase
  end

  assign ovf = ovf_q;
  assign ovf_hi = ovfh_q;

  a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M16 && inc && lo_q == 8'hFF && hi_q == 8'hFF) |=> (lo_q == 8'h00 && hi_q == 8'h00 && ovf_q));

  a_r4_reload_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MRLD && inc && lo_q == 8'hFF) |=> (lo_q == $past(hi_q) && ovf_q));

  a_r2_upper_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M13 && !reg_wr) |=> (lo_q[7:5] == $past(lo_q[7:5])));

  a_r8_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !reg_wr && mode != MSPL) |=> ($stable(lo_q) && $stable(hi_q)));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !(reg_wr && reg_addr == 2'd3)) |=> ovf_q);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0) |=> (lo_q == $past(reg_wdata)));

  a_r7_no_count_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_wr) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: tb/tb_tmr_channel.sv
module tb_tmr_channel;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, tick = 0, cnt_pin = 0, gate_pin = 0, reg_wr = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic ovf, ovf_hi;

  int compared = 0, mismatched = 0;
  int m_lo, m_hi, m_mode, m_ext, m_gate, m_run, m_runh, m_ov, m_ovh, s1, s2, prv, v;
  bit en, fl;

  tmr_channel dut (.clk, .rst_n, .tick, .cnt_pin, .gate_pin, .reg_wr, .reg_addr,
                   .reg_wdata, .reg_rdata, .ovf, .ovf_hi);

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_lo;
      1: return m_hi;
      2: return m_runh*32 + m_run*16 + m_gate*8 + m_ext*4 + m_mode;
      default: return m_ovh*2 + m_ov;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_hi = 0; m_mode = 0; m_ext = 0; m_gate = 0; m_run = 0; m_runh = 0;
      m_ov = 0; m_ovh = 0; s1 = 0; s2 = 0; prv = 0;
    end else begin
      en = m_run != 0 && (m_gate == 0 || gate_pin);
      fl = tick && prv != 0 && s2 == 0;
      if (reg_wr) begin
        case (reg_addr)
          0: m_lo = reg_wdata;
          1: m_hi = reg_wdata;
          2: begin m_mode = reg_wdata % 4; m_ext = reg_wdata[2]; m_gate = reg_wdata[3];
                   m_run = reg_wdata[4]; m_runh = reg_wdata[5]; end
          default: begin m_ov = reg_wdata[0]; m_ovh = reg_wdata[1]; end
        endcase
      end else begin
        if (en && (m_ext != 0 ? fl : tick)) begin
          case (m_mode)
            0: begin
              v = m_hi*32 + m_lo%32 + 1;
              if (v == 8192) begin v = 0; m_ov = 1; end
              m_hi = v/32; m_lo = (m_lo/32)*32 + v%32;
            end
            1: begin
              v = m_hi*256 + m_lo + 1;
              if (v == 65536) begin v = 0; m_ov = 1; end
              m_hi = v/256; m_lo = v%256;
            end
            2: if (m_lo == 255) begin m_lo = m_hi; m_ov = 1; end else m_lo++;
            default: begin
              if (m_lo == 255) m_ov = 1;
              m_lo = (m_lo + 1) % 256;
            end
          endcase
        end
        if (m_mode == 3 && m_runh != 0 && tick) begin
          if (m_hi == 255) m_ovh = 1;
          m_hi = (m_hi + 1) % 256;
        end
      end
      if (tick) prv = s2;
      s2 = s1;
      s1 = cnt_pin;
    end
    #2;
    check("model rdata", reg_rdata, model_read(reg_addr));
    check("model ovf", ovf, m_ov);
    check("model ovf_hi", ovf_hi, m_ovh);
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic rd(string tag, int a, int exp);
    reg_addr = a[1:0];
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(PERIOD*200000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd("R1 low", 0, 0); rd("R1 high", 1, 0); rd("R1 ctrl", 2, 0); rd("R1 flags", 3, 0);
    check("R1 ovf_hi", ovf_hi, 0);

    // R3 16-bit wrap
    wr(0, 'hFD); wr(1, 'hFF); wr(2, 'h11);
    ticks(2);
    rd("R3 low before wrap", 0, 'hFF); check("R3 no flag yet", ovf, 0);
    ticks(1);
    rd("R3 low wrap", 0, 0); rd("R3 high wrap", 1, 0); check("R3 flag", ovf, 1);

    // R9 sticky flag
    wr(2, 0);
    repeat (5) @(negedge clk);
    rd("R9 flag held", 3, 1);
    wr(3, 0);
    rd("R9 flag cleared", 3, 0);

    // R8 stopped holds
    wr(0, 'h42); ticks(10);
    rd("R8 frozen low", 0, 'h42); rd("R8 frozen high", 1, 0);

    // R2 13-bit
    wr(0, 'hE0); wr(1, 0); wr(2, 'h10);
    ticks(8191);
    rd("R2 high at max", 1, 'hFF); rd("R2 low at max", 0, 'hFF); check("R2 no flag", ovf, 0);
    ticks(1);
    rd("R2 high wrap", 1, 0); rd("R2 low keeps upper bits", 0, 'hE0); check("R2 flag", ovf, 1);
    wr(2, 0); wr(3, 0);

    // R4 auto-reload
    wr(0, 'hFE); wr(1, 'hF0); wr(2, 'h12);
    ticks(2);
    rd("R4 reloaded", 0, 'hF0); rd("R4 high unchanged", 1, 'hF0); check("R4 flag", ovf, 1);
    ticks(3);
    rd("R4 counts on", 0, 'hF3);
    wr(2, 0); wr(3, 0);

    // R5 split
    wr(0, 'hFF); wr(1, 'hFE); wr(2, 'h33);
    ticks(2);
    rd("R5 low", 0, 'h01); rd("R5 high", 1, 'h00);
    check("R5 low flag", ovf, 1); check("R5 high flag", ovf_hi, 1);
    wr(2, 'h23);
    ticks(3);
    rd("R5 low stopped", 0, 'h01); rd("R5 high runs alone", 1, 'h03);
    wr(2, 0); wr(3, 0);

    // R6 gate
    wr(0, 0); wr(1, 0); wr(2, 'h19);
    gate_pin = 0; ticks(5);
    rd("R6 gate low blocks", 0, 0);
    gate_pin = 1; ticks(5);
    rd("R6 gate high counts", 0, 5);
    gate_pin = 0; wr(2, 'h11); ticks(2);
    rd("R6 gate disabled", 0, 7);

    // R7 external source
    wr(0, 0); wr(2, 'h15);
    ticks(5);
    rd("R7 ticks ignored", 0, 0);
    @(negedge clk); tick = 1;
    for (int i = 0; i < 3; i++) begin
      cnt_pin = 1; repeat (4) @(negedge clk);
      cnt_pin = 0; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    tick = 0;
    rd("R7 falling edges", 0, 3);

    // R10 write beats increment
    wr(2, 'h11);
    @(negedge clk);
    tick = 1; reg_wr = 1; reg_addr = 0; reg_wdata = 'h55;
    @(negedge clk);
    tick = 0; reg_wr = 0;
    rd("R10 written value kept", 0, 'h55);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule